// File: doc/BRIEF.md
# Embedded-Sync Video Capture Port

This block takes an 8-bit 4:2:2 component video byte stream in ITU-R BT.656 form from a video decoder and turns it into stored words. It has no horizontal or vertical sync wires. The sample clock, a per-byte enable and the data byte are its only video inputs. The block recovers all line and field timing from the four-byte timing reference codes in the stream. Each code is checked against its protection bits before it is used. Field, blanking and line-active status come only from codes that pass the check.

Active-video bytes are packed into words and written into one shared capture buffer of 5120 bytes. The buffer is split into two logical channels. Channel A takes the lines of the first field (F=0) and channel B the lines of the second field (F=1). A split input, counted in 8-byte units, gives channel A its share. Channel B gets everything left over. Each channel is a FIFO within its share and has a sticky overflow flag. A reader pulls words out one at a time through a simple request/valid port. A one-cycle frame-done pulse marks the point where the second field ends and a new frame starts.

Top module: `vid_capture_port`

## Requirements
- R1: A timing code is the byte run 0xFF, 0x00, 0x00, XY, counting only bytes sampled with the enable high. The XY byte is laid out as bit7=1, bit6=F, bit5=V, bit4=H, with bits 3..0 equal to {V^H, F^H, F^V, F^V^H}. H=0 marks the start of active video and H=1 marks its end. After each accepted code, the field output follows F and the blanking output follows V.
- R2: A code whose bit7 is 0 or whose low nibble does not match increments the saturating error counter. It leaves field, blanking, line-active and frame tracking unchanged. None of its four bytes is stored.
- R3: Bytes are stored only between a start code with V=0 and the next end code. A start code with V=1 stores nothing. The preamble and XY bytes of a code are never stored.
- R4: Stored bytes are packed four per 32-bit word, with the first byte in bits 7:0. If a line ends with a partial word, that word is written with its unused upper bytes set to zero.
- R5: Lines captured while F=0 go to channel A (index 0 of the per-channel flags). Lines captured while F=1 go to channel B (index 1).
- R6: Channel A holds `split_units`×8 bytes, with the split clamped to 640 units (the whole buffer). Channel B holds the rest. Each channel returns its words in the order they were written.
- R7: A word written to a full channel is dropped and sets that channel's overflow flag. The flag stays set until reset, and the other channel is unaffected.
- R8: A read request on a channel that holds data removes its oldest word. That word appears on `rd_data` with `rd_valid` high in the next cycle. A request on an empty channel produces no `rd_valid`.
- R9: `frame_done` pulses high for exactly one cycle when an accepted code changes F from 1 to 0.
- R10: Bytes presented while `cap_en` is low are ignored. They are neither stored nor counted toward a timing code.
- R11: After reset both channels are empty, both overflow flags and the error count are zero, field is 0, blanking is 1 and no line is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Byte sample enable |
| vid_data | input | 8 | BT.656 stream byte |
| split_units | input | 10 | Channel A share in 8-byte units; hold stable while capturing |
| rd_en | input | 1 | Read request, one word per cycle |
| rd_ch | input | 1 | Channel to read: 0 = A, 1 = B |
| rd_data | output | 32 | Word returned by the read |
| rd_valid | output | 1 | `rd_data` holds a word this cycle |
| chan_empty | output | 2 | Per-channel empty flags, bit 0 = A |
| chan_ovf | output | 2 | Per-channel sticky overflow flags, bit 0 = A |
| field_o | output | 1 | F bit of the last accepted code |
| vblank_o | output | 1 | V bit of the last accepted code |
| line_active_o | output | 1 | Inside a stored active line |
| code_err_cnt | output | 8 | Saturating count of rejected timing codes |
| frame_done | output | 1 | One-cycle pulse at the F 1-to-0 change |

## Verification
A wrong look-behind state shows up at `rd_data` as stray 0xFF or 0x00 bytes inside a word, or as a missing last byte. This is visible on the first word read back after the line. A wrong lane counter shifts every following byte within its word, so the first full word read after the line already shows the error. A corrupted occupancy or pointer shows up in the empty and overflow flags one cycle after the bad write. It also shows up as out-of-order words when the channel is drained. Sync-state faults reach `line_active_o`, `field_o` and `frame_done` within one cycle of the XY byte.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    localparam logic [7:0] TRS_LEAD = 8'hFF;
    localparam logic [7:0] TRS_ZERO = 8'h00;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } vcap_ch_e;

    // XY check: marker bit set and protection nibble consistent with F/V/H
    function automatic logic xy_valid(input logic [7:0] xy);
        logic f, v, h;
        f = xy[6];
        v = xy[5];
        h = xy[4];
        return xy[7] && (xy[3:0] == {v ^ h, f ^ h, f ^ v, f ^ v ^ h});
    endfunction

endpackage

// File: rtl/vcap_sync_decode.sv
module vcap_sync_decode
    import vcap_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [7:0]       vid,
    output logic             byte_vld,
    output logic [7:0]       byte_out,
    output vcap_ch_e         byte_ch,
    output logic             eol,
    output logic             field,
    output logic             vblank,
    output logic             active,
    output logic [ERR_W-1:0] err_cnt,
    output logic             frame_done
);

    localparam int LOOK = 3;

    typedef struct packed {
        logic [LOOK-1:0][7:0] hist;   // [0] newest
        logic [LOOK-1:0]      hv;     // byte entered during an active line
        logic                 active;
        logic                 field;
        logic                 vblank;
        logic                 fseen;
        logic [ERR_W-1:0]     err;
        logic                 fdone;
        logic                 eol;
        logic                 ovld;
        logic [7:0]           obyte;
        vcap_ch_e             och;
    } sd_t;

    sd_t st_q, st_d;
    logic preamble;

    assign preamble = (st_q.hist[2] == TRS_LEAD) && (st_q.hist[1] == TRS_ZERO)
                   && (st_q.hist[0] == TRS_ZERO);

    always_comb begin
        st_d       = st_q;
        st_d.fdone = 1'b0;
        st_d.eol   = 1'b0;
        st_d.ovld  = 1'b0;
        if (cap_en) begin
            st_d.hist = {st_q.hist[LOOK-2:0], vid};
            if (preamble) begin
                // the preamble bytes and the XY byte never reach storage
                st_d.hv = '0;
                if (xy_valid(vid)) begin
                    if (vid[4]) begin
                        st_d.eol    = st_q.active;
                        st_d.active = 1'b0;
                    end else begin
                        st_d.active = !vid[5];
                    end
                    st_d.field  = vid[6];
                    st_d.vblank = vid[5];
                    st_d.fseen  = 1'b1;
                    st_d.fdone  = st_q.fseen && st_q.field && !vid[6];
                end else if (st_q.err != '1) begin
                    st_d.err = st_q.err + 1'b1;
                end
            end else begin
                st_d.hv    = {st_q.hv[LOOK-2:0], st_q.active};
                st_d.ovld  = st_q.hv[LOOK-1];
                st_d.obyte = st_q.hist[LOOK-1];
                st_d.och   = st_q.field ? CH_B : CH_A;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.vblank <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_vld   = st_q.ovld;
    assign byte_out   = st_q.obyte;
    assign byte_ch    = st_q.och;
    assign eol        = st_q.eol;
    assign field      = st_q.field;
    assign vblank     = st_q.vblank;
    assign active     = st_q.active;
    assign err_cnt    = st_q.err;
    assign frame_done = st_q.fdone;

    assert_frame_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fdone |=> !st_q.fdone);
    assert_err_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err >= $past(st_q.err));
    assert_open_unblanked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> !st_q.vblank);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(st_q.err) && $stable(st_q.field) && !st_q.ovld));

endmodule

// File: rtl/vcap_packer.sv
module vcap_packer
    import vcap_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_vld,
    input  logic [7:0]              byte_in,
    input  vcap_ch_e                byte_ch,
    input  logic                    eol,
    output logic                    word_vld,
    output logic [WORD_BYTES*8-1:0] word_out,
    output vcap_ch_e                word_ch
);

    localparam int WORD_W = WORD_BYTES * 8;
    localparam int LW     = $clog2(WORD_BYTES);
    localparam logic [LW-1:0] LAST_LANE = LW'(WORD_BYTES - 1);

    typedef struct packed {
        logic [LW-1:0]     lane;
        logic [WORD_W-1:0] acc;
        vcap_ch_e          ch;
        logic              ovld;
        logic [WORD_W-1:0] oword;
        vcap_ch_e          och;
    } pk_t;

    pk_t pk_q, pk_d;

    always_comb begin
        pk_d      = pk_q;
        pk_d.ovld = 1'b0;
        if (byte_vld) begin
            if (pk_q.lane == '0) begin
                pk_d.ch = byte_ch;
            end
            pk_d.acc[int'(pk_q.lane)*8 +: 8] = byte_in;
            if (pk_q.lane == LAST_LANE) begin
                pk_d.ovld  = 1'b1;
                pk_d.oword = pk_d.acc;
                pk_d.och   = pk_d.ch;
                pk_d.lane  = '0;
                pk_d.acc   = '0;
            end else begin
                pk_d.lane = pk_q.lane + 1'b1;
            end
        end else if (eol && (pk_q.lane != '0)) begin
            // partial tail word: unused upper bytes are already zero
            pk_d.ovld  = 1'b1;
            pk_d.oword = pk_q.acc;
            pk_d.och   = pk_q.ch;
            pk_d.lane  = '0;
            pk_d.acc   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign word_vld = pk_q.ovld;
    assign word_out = pk_q.oword;
    assign word_ch  = pk_q.och;

    assert_tail_empty_after_eol_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eol && !byte_vld) |=> (pk_q.lane == '0));

endmodule

// File: rtl/vcap_split_buffer.sv
module vcap_split_buffer
    import vcap_pkg::*;
#(
    parameter int BUF_BYTES  = 5120,
    parameter int WORD_BYTES = 4,
    parameter int UNIT_BYTES = 8,
    parameter int SPLIT_W    = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SPLIT_W-1:0]      split_units,
    input  logic                    wr_vld,
    input  logic [WORD_BYTES*8-1:0] wr_word,
    input  vcap_ch_e                wr_ch,
    input  logic                    rd_en,
    input  vcap_ch_e                rd_ch,
    output logic [WORD_BYTES*8-1:0] rd_data,
    output logic                    rd_valid,
    output logic [1:0]              empty,
    output logic [1:0]              ovf
);

    localparam int WORD_W    = WORD_BYTES * 8;
    localparam int DEPTH     = BUF_BYTES / WORD_BYTES;
    localparam int PW        = $clog2(DEPTH + 1);
    localparam int UNITS_MAX = BUF_BYTES / UNIT_BYTES;
    localparam int WPU       = UNIT_BYTES / WORD_BYTES;
    localparam int NCH       = 2;

    typedef struct packed {
        logic [NCH-1:0][PW-1:0] wp;
        logic [NCH-1:0][PW-1:0] rp;
        logic [NCH-1:0][PW-1:0] cnt;
        logic [NCH-1:0]         ovf;
        logic                   rvld;
    } bf_t;

    bf_t bf_q, bf_d;

    logic [NCH-1:0][PW-1:0] cap;
    logic [NCH-1:0][PW-1:0] base;
    logic                   push, pop, we, re;
    logic [PW-1:0]          waddr, raddr;
    logic [WORD_W-1:0]      mem [DEPTH];
    logic [WORD_W-1:0]      rdata_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input logic [PW-1:0] lim);
        return (p + 1'b1 == lim) ? '0 : p + 1'b1;
    endfunction

    // Share boundaries derived from the split setting
    always_comb begin
        int units;
        units   = (int'(split_units) > UNITS_MAX) ? UNITS_MAX : int'(split_units);
        cap[0]  = PW'(units * WPU);
        cap[1]  = PW'(DEPTH) - cap[0];
        base[0] = '0;
        base[1] = cap[0];
    end

    always_comb begin
        bf_d      = bf_q;
        bf_d.rvld = 1'b0;
        we        = 1'b0;
        re        = 1'b0;
        waddr     = '0;
        raddr     = '0;
        push      = wr_vld && (bf_q.cnt[wr_ch] != cap[wr_ch]);
        pop       = rd_en && (bf_q.cnt[rd_ch] != '0);
        if (wr_vld && !push) begin
            bf_d.ovf[wr_ch] = 1'b1;
        end
        if (push) begin
            we              = 1'b1;
            waddr           = base[wr_ch] + bf_q.wp[wr_ch];
            bf_d.wp[wr_ch]  = bump(bf_q.wp[wr_ch], cap[wr_ch]);
        end
        if (pop) begin
            re              = 1'b1;
            raddr           = base[rd_ch] + bf_q.rp[rd_ch];
            bf_d.rp[rd_ch]  = bump(bf_q.rp[rd_ch], cap[rd_ch]);
            bf_d.rvld       = 1'b1;
        end
        for (int c = 0; c < NCH; c++) begin
            if ((push && (int'(wr_ch) == c)) && !(pop && (int'(rd_ch) == c))) begin
                bf_d.cnt[c] = bf_q.cnt[c] + 1'b1;
            end else if (!(push && (int'(wr_ch) == c)) && (pop && (int'(rd_ch) == c))) begin
                bf_d.cnt[c] = bf_q.cnt[c] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bf_q <= '0;
        end else begin
            bf_q <= bf_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wr_word;
        end
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rd_data  = rdata_q;
    assign rd_valid = bf_q.rvld;
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            empty[c] = (bf_q.cnt[c] == '0);
        end
    end
    assign ovf = bf_q.ovf;

    assert_fill_bound_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bf_q.cnt[0] <= cap[0]);
    assert_fill_bound_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bf_q.cnt[1] <= cap[1]);
    assert_no_overflow_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bf_q.ovf != 2'b00) |=> ((bf_q.ovf & $past(bf_q.ovf)) == $past(bf_q.ovf)));
    assert_rd_valid_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bf_q.rvld |-> $past(rd_en));

endmodule

// File: rtl/vid_capture_port.sv
module vid_capture_port
    import vcap_pkg::*;
#(
    parameter int BUF_BYTES  = 5120,
    parameter int WORD_BYTES = 4,
    parameter int UNIT_BYTES = 8,
    parameter int SPLIT_W    = 10,
    parameter int ERR_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en,
    input  logic [7:0]              vid_data,
    input  logic [SPLIT_W-1:0]      split_units,
    input  logic                    rd_en,
    input  logic                    rd_ch,
    output logic [WORD_BYTES*8-1:0] rd_data,
    output logic                    rd_valid,
    output logic [1:0]              chan_empty,
    output logic [1:0]              chan_ovf,
    output logic                    field_o,
    output logic                    vblank_o,
    output logic                    line_active_o,
    output logic [ERR_W-1:0]        code_err_cnt,
    output logic                    frame_done
);

    localparam int WORD_W = WORD_BYTES * 8;

    logic              sd_vld, sd_eol, pk_vld;
    logic [7:0]        sd_byte;
    vcap_ch_e          sd_ch, pk_ch, rd_sel;
    logic [WORD_W-1:0] pk_word;

    assign rd_sel = rd_ch ? CH_B : CH_A;

    vcap_sync_decode #(.ERR_W(ERR_W)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .vid        (vid_data),
        .byte_vld   (sd_vld),
        .byte_out   (sd_byte),
        .byte_ch    (sd_ch),
        .eol        (sd_eol),
        .field      (field_o),
        .vblank     (vblank_o),
        .active     (line_active_o),
        .err_cnt    (code_err_cnt),
        .frame_done (frame_done)
    );

    vcap_packer #(.WORD_BYTES(WORD_BYTES)) i_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (sd_vld),
        .byte_in  (sd_byte),
        .byte_ch  (sd_ch),
        .eol      (sd_eol),
        .word_vld (pk_vld),
        .word_out (pk_word),
        .word_ch  (pk_ch)
    );

    vcap_split_buffer #(
        .BUF_BYTES  (BUF_BYTES),
        .WORD_BYTES (WORD_BYTES),
        .UNIT_BYTES (UNIT_BYTES),
        .SPLIT_W    (SPLIT_W)
    ) i_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .split_units (split_units),
        .wr_vld      (pk_vld),
        .wr_word     (pk_word),
        .wr_ch       (pk_ch),
        .rd_en       (rd_en),
        .rd_ch       (rd_sel),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .empty       (chan_empty),
        .ovf         (chan_ovf)
    );

endmodule

// File: tb/test_vid_capture_port.sv
module test_vid_capture_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic [7:0]  vid_data = 8'h00;
    logic [9:0]  split_units = 10'd4;
    logic        rd_en = 1'b0;
    logic        rd_ch = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [1:0]  chan_empty, chan_ovf;
    logic        field_o, vblank_o, line_active_o, frame_done;
    logic [7:0]  code_err_cnt;

    int tests = 0;
    int fails = 0;
    int fd_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vid_capture_port i_vid_capture_port (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .vid_data(vid_data),
        .split_units(split_units), .rd_en(rd_en), .rd_ch(rd_ch),
        .rd_data(rd_data), .rd_valid(rd_valid), .chan_empty(chan_empty),
        .chan_ovf(chan_ovf), .field_o(field_o), .vblank_o(vblank_o),
        .line_active_o(line_active_o), .code_err_cnt(code_err_cnt),
        .frame_done(frame_done)
    );

    always @(negedge clk) begin
        if (!rst_n) fd_cnt = 0;
        else if (frame_done) fd_cnt = fd_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        vid_data = b;
        cap_en   = 1'b1;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap_en   = 1'b0;
            vid_data = 8'hFF;
        end
    endtask

    task automatic code(input logic f, input logic v, input logic h, input bit bad);
        put(8'hFF); put(8'h00); put(8'h00);
        put(mk_xy(f, v, h) ^ (bad ? 8'h01 : 8'h00));
    endtask

    task automatic line(input logic f, input int n, input logic [7:0] first);
        code(f, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < n; i++) put(first + 8'(i));
        code(f, 1'b0, 1'b1, 1'b0);
        gap(4);
    endtask

    task automatic rd_expect(input logic ch, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_ch = ch; cap_en = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, 32'(rd_valid), 32'd1);
        chk(tag, rd_data, exp);
    endtask

    task automatic rd_none(input logic ch, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_ch = ch; cap_en = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, 32'(rd_valid), 32'd0);
    endtask

    task automatic do_reset(input logic [9:0] split);
        @(negedge clk);
        rst_n = 1'b0; cap_en = 1'b0; rd_en = 1'b0; split_units = split;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        gap(1);
    endtask

    task automatic t_reset;
        chk("R11 empty", 32'(chan_empty), 32'h3);
        chk("R11 ovf", 32'(chan_ovf), 32'h0);
        chk("R11 err", 32'(code_err_cnt), 32'h0);
        chk("R11 field", 32'(field_o), 32'h0);
        chk("R11 vblank", 32'(vblank_o), 32'h1);
        chk("R11 active", 32'(line_active_o), 32'h0);
        chk("R11 frame_done", 32'(frame_done), 32'h0);
    endtask

    task automatic t_basic;
        code(1'b0, 1'b0, 1'b0, 1'b0);
        gap(2);
        chk("R3 active after SAV", 32'(line_active_o), 32'h1);
        chk("R1 vblank follows V", 32'(vblank_o), 32'h0);
        for (int i = 1; i <= 5; i++) put(8'(i));
        gap(3);   // R10: FF bytes with enable low are ignored
        for (int i = 6; i <= 10; i++) put(8'(i));
        code(1'b0, 1'b0, 1'b1, 1'b0);
        gap(4);
        chk("R3 inactive after EAV", 32'(line_active_o), 32'h0);
        chk("R5 B untouched", 32'(chan_empty[1]), 32'h1);
        rd_expect(1'b0, 32'h04030201, "R4 word0");
        rd_expect(1'b0, 32'h08070605, "R10 word1");
        rd_expect(1'b0, 32'h00000A09, "R4 padded tail");
        rd_none(1'b0, "R8 empty read");
        chk("R6 fifo drained", 32'(chan_empty), 32'h3);
    endtask

    task automatic t_blank;
        code(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) put(8'h40 + 8'(i));
        code(1'b0, 1'b1, 1'b1, 1'b0);
        gap(4);
        chk("R3 blanking not stored", 32'(chan_empty), 32'h3);
        chk("R3 no active in blanking", 32'(line_active_o), 32'h0);
        chk("R1 vblank set", 32'(vblank_o), 32'h1);
    endtask

    task automatic t_badcode;
        code(1'b0, 1'b0, 1'b0, 1'b0);
        put(8'h11); put(8'h22); put(8'h33); put(8'h44);
        code(1'b0, 1'b0, 1'b1, 1'b1);
        gap(2);
        chk("R2 error counted", 32'(code_err_cnt), 32'h1);
        chk("R2 line stays active", 32'(line_active_o), 32'h1);
        put(8'h55); put(8'h66); put(8'h77); put(8'h88);
        code(1'b0, 1'b0, 1'b1, 1'b0);
        gap(4);
        rd_expect(1'b0, 32'h44332211, "R2 data before bad code");
        rd_expect(1'b0, 32'h88776655, "R2 bad code bytes dropped");
        rd_none(1'b0, "R2 nothing extra");
    endtask

    task automatic t_field_b;
        line(1'b1, 4, 8'hA1);
        chk("R5 field B", 32'(chan_empty), 32'h1);
        chk("R1 field follows F", 32'(field_o), 32'h1);
        rd_none(1'b0, "R5 A empty");
        rd_expect(1'b1, 32'hA4A3A2A1, "R5 B word");
    endtask

    task automatic t_frame;
        int c0;
        c0 = fd_cnt;
        code(1'b0, 1'b1, 1'b0, 1'b0);
        gap(2);
        chk("R9 pulse on F 1->0", 32'(fd_cnt), 32'(c0 + 1));
        code(1'b0, 1'b1, 1'b1, 1'b0);
        code(1'b0, 1'b1, 1'b0, 1'b0);
        gap(2);
        chk("R9 no pulse F 0->0", 32'(fd_cnt), 32'(c0 + 1));
        code(1'b1, 1'b1, 1'b0, 1'b0);
        gap(2);
        chk("R9 no pulse F 0->1", 32'(fd_cnt), 32'(c0 + 1));
        code(1'b0, 1'b1, 1'b0, 1'b1);
        gap(2);
        chk("R2 bad code no pulse", 32'(fd_cnt), 32'(c0 + 1));
        chk("R2 bad code keeps field", 32'(field_o), 32'h1);
        code(1'b0, 1'b1, 1'b0, 1'b0);
        gap(2);
        chk("R9 second pulse", 32'(fd_cnt), 32'(c0 + 2));
    endtask

    task automatic t_overflow;
        do_reset(10'd1);
        line(1'b0, 12, 8'h01);
        chk("R7 A overflow", 32'(chan_ovf), 32'h1);
        rd_expect(1'b0, 32'h04030201, "R6 A word0");
        rd_expect(1'b0, 32'h08070605, "R6 A word1");
        rd_none(1'b0, "R7 third dropped");
        line(1'b1, 4, 8'hB1);
        rd_expect(1'b1, 32'hB4B3B2B1, "R7 B unaffected");
        chk("R7 sticky A only", 32'(chan_ovf), 32'h1);
    endtask

    task automatic t_exact;
        do_reset(10'd1);
        line(1'b0, 8, 8'h21);
        chk("R6 exact fill no ovf", 32'(chan_ovf), 32'h0);
        rd_expect(1'b0, 32'h24232221, "R6 fill word0");
        rd_expect(1'b0, 32'h28272625, "R6 fill word1");
    endtask

    task automatic t_clamp;
        do_reset(10'd1023);
        line(1'b1, 4, 8'hC1);
        chk("R6 clamp leaves B no room", 32'(chan_ovf), 32'h2);
        line(1'b0, 4, 8'hD1);
        rd_expect(1'b0, 32'hD4D3D2D1, "R6 clamp A whole buffer");
    endtask

    initial begin
        do_reset(10'd4);
        t_reset();
        t_basic();
        t_blank();
        t_badcode();
        t_field_b();
        t_frame();
        t_overflow();
        t_exact();
        t_clamp();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule